// File: doc/BRIEF.md
# SIMD Scatter/Gather Line Coalescer

This block takes one vector memory message of up to sixteen lanes. Each lane carries a 32-bit byte address and an enable bit, and a write message also carries per-lane data. The block turns the message into the smallest set of 64-byte line requests. No line is requested twice within one message. Each request carries the line address, a sixteen-bit dword mask and, for writes, the lane data merged into line position.

For a read (gather) message, one 64-byte response comes back for each line request, in request order. The block copies each returned dword to every lane that asked for it. It then presents the whole sixteen-lane result on a 64-byte return bus and marks completion with a one-cycle done pulse. Enabled lanes whose address is not dword aligned are dropped, and an error flag is reported with the done pulse.

Top module: `sg_line_merger`

## Requirements
- R1: A lane's line address is address bits [31:6] and its dword slot within the line is bits [5:2]. Slot s occupies bits [32*s+31:32*s] of req_data and rsp_data, and bit s of req_mask.
- R2: Each distinct line touched by the valid lanes of a message is requested exactly once. A message whose lanes all fall in one line produces exactly one request.
- R3: Requests are issued in ascending order of the lowest-numbered valid lane that touches each line.
- R4: req_mask has bit s set exactly when some valid lane of the message targets slot s of that line. It is never zero while req_valid is high.
- R5: For a write message (req_write=1), req_data holds each masked slot's lane data. When several lanes write one slot, the highest-numbered lane wins. Unmasked slots are zero, and req_data is zero for reads.
- R6: For a read message, ret_data lane i (bits [32*i+31:32*i]) equals the response dword in that lane's slot once done is high. Disabled or dropped lanes, and all lanes of a write message, return zero.
- R7: An enabled lane with address bits [1:0] not zero generates no request. err is high during done if and only if such a lane existed.
- R8: done is a one-cycle pulse. It comes in the cycle after the last line response of a read, or after the last request handshake of a write, or the cycle after acceptance when no lane is valid. No request is pending while done is high.
- R9: While req_valid is high and req_ready is low, req_valid, req_line, req_mask and req_data hold steady.
- R10: msg_ready is high only when no message is in progress. It is high again in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Message accepted when high with msg_valid |
| msg_write | input | 1 | 1 = scatter (write), 0 = gather (read) |
| msg_en | input | 16 | Per-lane enable |
| msg_addr | input | 512 | Per-lane byte address, lane i at [32*i+31:32*i] |
| msg_wdata | input | 512 | Per-lane write data, lane i at [32*i+31:32*i] |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request taken |
| req_write | output | 1 | Request is a write |
| req_line | output | 26 | Line address (byte address bits [31:6]) |
| req_mask | output | 16 | Dword slots touched |
| req_data | output | 512 | Merged write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 512 | Read response line |
| done | output | 1 | Message complete pulse |
| err | output | 1 | Misaligned lane seen, valid with done |
| ret_data | output | 512 | Per-lane returned read data |

## Verification
Two things happen in the same scan cycle: the misaligned-lane drop and the line merge. The bench sets up messages in which misaligned lanes sit in the same line, and even the same slot, as aligned lanes. It then checks that the request mask leaves them out, that the line is still requested once, that their return value is zero and that err rises with done. A second overlap comes from the last read response: it fills the return bus and schedules done together. The bench checks the returned values and the done pulse at the first sample after that response. A sweep covers every single-lane and slot position, and several hundred seeded mixed messages draw from four lines to force merges.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } sg_state_e;
endpackage

// File: rtl/sg_leader_pick.sv
// Finds the lowest-numbered lane still pending.
module sg_leader_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  pend,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sg_line_group.sv
// Collects all pending lanes sharing the leader's line; builds mask and merged data.
module sg_line_group #(
  parameter int LANES  = 16,
  parameter int LW     = 26,
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4,
  parameter int DW     = 32,
  parameter int IDX_W  = 4
) (
  input  logic [LANES-1:0]             pend,
  input  logic [IDX_W-1:0]             leader,
  input  logic [LANES-1:0][LW-1:0]     lane_line,
  input  logic [LANES-1:0][SLOT_W-1:0] lane_slot,
  input  logic [LANES-1:0][DW-1:0]     lane_data,
  output logic [LANES-1:0]             grp,
  output logic [LW-1:0]                line,
  output logic [SLOTS-1:0]             mask,
  output logic [SLOTS-1:0][DW-1:0]     mdata
);
  always_comb begin
    line  = lane_line[leader];
    grp   = '0;
    mask  = '0;
    mdata = '0;
    // ascending scan: later (higher) lanes overwrite a shared slot
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (lane_line[i] == line)) begin
        grp[i]              = 1'b1;
        mask[lane_slot[i]]  = 1'b1;
        mdata[lane_slot[i]] = lane_data[i];
      end
    end
  end
endmodule

// File: rtl/sg_return_scatter.sv
// Selects, for every lane, the response dword at that lane's slot.
module sg_return_scatter #(
  parameter int LANES  = 16,
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4,
  parameter int DW     = 32
) (
  input  logic [LANES-1:0][SLOT_W-1:0] lane_slot,
  input  logic [SLOTS-1:0][DW-1:0]     rsp_words,
  output logic [LANES-1:0][DW-1:0]     lane_val
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_val[g] = rsp_words[lane_slot[g]];
  end
endmodule

// File: rtl/sg_line_merger.sv
module sg_line_merger #(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DW         = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    msg_valid,
  output logic                                    msg_ready,
  input  logic                                    msg_write,
  input  logic [LANES-1:0]                        msg_en,
  input  logic [LANES*ADDR_W-1:0]                 msg_addr,
  input  logic [LANES*DW-1:0]                     msg_wdata,
  output logic                                    req_valid,
  input  logic                                    req_ready,
  output logic                                    req_write,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    req_line,
  output logic [LINE_BYTES/(DW/8)-1:0]            req_mask,
  output logic [LINE_BYTES*8-1:0]                 req_data,
  input  logic                                    rsp_valid,
  input  logic [LINE_BYTES*8-1:0]                 rsp_data,
  output logic                                    done,
  output logic                                    err,
  output logic [LANES*DW-1:0]                     ret_data
);
  import sg_pkg::*;

  localparam int DW_BYTES  = DW / 8;
  localparam int AL_W      = $clog2(DW_BYTES);
  localparam int OFS_W     = $clog2(LINE_BYTES);
  localparam int LW        = ADDR_W - OFS_W;
  localparam int SLOTS     = LINE_BYTES / DW_BYTES;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int KEEP_W    = ADDR_W - AL_W;
  localparam int IDX_W     = $clog2(LANES);

  // ---------------- input lane view ----------------
  logic [LANES-1:0]             lane_ok;
  logic [LANES-1:0][KEEP_W-1:0] in_addr;
  logic [LANES-1:0][DW-1:0]     in_data;

  for (genvar g = 0; g < LANES; g++) begin : g_in
    assign lane_ok[g] = (msg_addr[g*ADDR_W +: AL_W] == '0);
    assign in_addr[g] = msg_addr[g*ADDR_W + AL_W +: KEEP_W];
    assign in_data[g] = msg_wdata[g*DW +: DW];
  end

  // ---------------- state ----------------
  sg_state_e                     state_q, state_n;
  logic [LANES-1:0]              pend_q, pend_n;
  logic                          err_q, err_n;
  logic [LANES-1:0][DW-1:0]      ret_q, ret_n;
  logic [LANES-1:0][KEEP_W-1:0]  addr_q;
  logic [LANES-1:0][DW-1:0]      data_q;
  logic                          write_q;
  logic [LANES-1:0]              grp_q;
  logic                          load, take;

  // ---------------- lane fields ----------------
  logic [LANES-1:0][LW-1:0]      lane_line;
  logic [LANES-1:0][SLOT_W-1:0]  lane_slot;

  for (genvar g = 0; g < LANES; g++) begin : g_fld
    assign lane_line[g] = addr_q[g][KEEP_W-1 -: LW];
    assign lane_slot[g] = addr_q[g][SLOT_W-1:0];
  end

  // ---------------- datapath ----------------
  logic [IDX_W-1:0]              leader;
  logic [LANES-1:0]              grp;
  logic [LW-1:0]                 grp_line;
  logic [SLOTS-1:0]              grp_mask;
  logic [SLOTS-1:0][DW-1:0]      grp_data;
  logic [SLOTS-1:0][DW-1:0]      rsp_words;
  logic [LANES-1:0][DW-1:0]      lane_val;

  sg_leader_pick #(.N(LANES), .IW(IDX_W)) pick_i (
    .pend (pend_q),
    .idx  (leader)
  );

  sg_line_group #(
    .LANES(LANES), .LW(LW), .SLOTS(SLOTS), .SLOT_W(SLOT_W),
    .DW(DW), .IDX_W(IDX_W)
  ) group_i (
    .pend      (pend_q),
    .leader    (leader),
    .lane_line (lane_line),
    .lane_slot (lane_slot),
    .lane_data (data_q),
    .grp       (grp),
    .line      (grp_line),
    .mask      (grp_mask),
    .mdata     (grp_data)
  );

  assign rsp_words = rsp_data;

  sg_return_scatter #(
    .LANES(LANES), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .DW(DW)
  ) scat_i (
    .lane_slot (lane_slot),
    .rsp_words (rsp_words),
    .lane_val  (lane_val)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    err_n   = err_q;
    ret_n   = ret_q;
    load    = 1'b0;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (msg_valid) begin
          load    = 1'b1;
          pend_n  = msg_en & lane_ok;
          err_n   = |(msg_en & ~lane_ok);
          ret_n   = '0;
          state_n = (|(msg_en & lane_ok)) ? ST_ISSUE : ST_FIN;
        end
      end
      ST_ISSUE: begin
        if (req_ready) begin
          take   = 1'b1;
          pend_n = pend_q & ~grp;
          if (!write_q)                state_n = ST_WAIT;
          else if (|(pend_q & ~grp))   state_n = ST_ISSUE;
          else                         state_n = ST_FIN;
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          for (int i = 0; i < LANES; i++) begin
            if (grp_q[i]) ret_n[i] = lane_val[i];
          end
          state_n = (|pend_q) ? ST_ISSUE : ST_FIN;
        end
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      err_q   <= 1'b0;
      ret_q   <= '0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      err_q   <= err_n;
      ret_q   <= ret_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q  <= in_addr;
      data_q  <= in_data;
      write_q <= msg_write;
    end
    if (take) begin
      grp_q <= grp;
    end
  end

  // ---------------- outputs ----------------
  assign msg_ready = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_ISSUE);
  assign req_write = write_q;
  assign req_line  = grp_line;
  assign req_mask  = grp_mask;
  assign req_data  = write_q ? grp_data : '0;
  assign done      = (state_q == ST_FIN);
  assign err       = err_q;
  assign ret_data  = ret_q;
endmodule

// File: rtl/sg_line_merger_chk.sv
module sg_line_merger_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DW         = 32
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 msg_ready,
  input logic                                 req_valid,
  input logic                                 req_ready,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] req_line,
  input logic [LINE_BYTES/(DW/8)-1:0]         req_mask,
  input logic [LINE_BYTES*8-1:0]              req_data,
  input logic                                 done
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line)
                                   && $stable(req_mask) && $stable(req_data)));

  // R4
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_mask != '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || done) |-> !msg_ready);

  // R10
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> msg_ready);
endmodule

bind sg_line_merger sg_line_merger_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DW(DW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_ready (msg_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_line  (req_line),
  .req_mask  (req_mask),
  .req_data  (req_data),
  .done      (done)
);

// File: tb/sg_line_merger_tb_top.sv
module sg_line_merger_tb_top;
  logic          clk;
  logic          rst_n;
  logic          msg_valid;
  logic          msg_ready;
  logic          msg_write;
  logic [15:0]   msg_en;
  logic [511:0]  msg_addr;
  logic [511:0]  msg_wdata;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [25:0]   req_line;
  logic [15:0]   req_mask;
  logic [511:0]  req_data;
  logic          rsp_valid;
  logic [511:0]  rsp_data;
  logic          done;
  logic          err;
  logic [511:0]  ret_data;

  sg_line_merger dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_write(msg_write),
    .msg_en(msg_en), .msg_addr(msg_addr), .msg_wdata(msg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_mask(req_mask), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .err(err), .ret_data(ret_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned nchk  = 0;
  int unsigned nfail = 0;
  int unsigned vec   = 0;
  logic [31:0] seed  = 32'h1357_9BDF;

  logic        t_wr;
  logic [15:0] t_en;
  logic [31:0] t_addr [16];
  logic [31:0] t_data [16];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s vec=%0d actual=%h expected=%h", rq, what, vec, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [29:0] dwa);
    return (32'(dwa) * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic run_msg();
    logic [15:0]  v;
    logic [25:0]  e_line [16];
    int           exp_n;
    logic         exp_err;
    int           req_k;
    int           guard;
    bit           found;
    logic [15:0]  em;
    logic [511:0] ed;
    logic [511:0] er;
    vec++;
    // expected model
    exp_n = 0;
    exp_err = 1'b0;
    for (int i = 0; i < 16; i++) begin
      v[i] = t_en[i] && (t_addr[i][1:0] == 2'b00);
      if (t_en[i] && t_addr[i][1:0] != 2'b00) exp_err = 1'b1;
      if (v[i]) begin
        found = 1'b0;
        for (int k = 0; k < exp_n; k++) if (e_line[k] == t_addr[i][31:6]) found = 1'b1;
        if (!found) begin e_line[exp_n] = t_addr[i][31:6]; exp_n++; end
      end
    end
    // drive message
    msg_write = t_wr;
    msg_en    = t_en;
    for (int i = 0; i < 16; i++) begin
      msg_addr[i*32 +: 32]  = t_addr[i];
      msg_wdata[i*32 +: 32] = t_data[i];
    end
    msg_valid = 1'b1;
    guard = 0;
    while (!msg_ready && guard < 50) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
    msg_en    = '0;
    if (exp_n > 0) chk(!msg_ready, "R10", "busy ready", 512'(msg_ready), 512'(0));
    req_k = 0;
    guard = 0;
    while (req_k < exp_n && guard < 200) begin
      if (req_valid) begin
        em = '0;
        ed = '0;
        for (int i = 0; i < 16; i++) begin
          if (v[i] && t_addr[i][31:6] == e_line[req_k]) begin
            em[t_addr[i][5:2]] = 1'b1;
            if (t_wr) ed[32*t_addr[i][5:2] +: 32] = t_data[i];
          end
        end
        chk(req_line == e_line[req_k], "R3", "line order", 512'(req_line), 512'(e_line[req_k]));
        chk(req_mask == em, "R4", "mask", 512'(req_mask), 512'(em));
        chk(req_data == ed, "R5", "merged data", req_data, ed);
        chk(req_write == t_wr, "R1", "write flag", 512'(req_write), 512'(t_wr));
        repeat ((vec + req_k) % 3) @(negedge clk);
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
        if (!t_wr) begin
          repeat (vec % 2) @(negedge clk);
          for (int s = 0; s < 16; s++)
            rsp_data[s*32 +: 32] = mem_word({e_line[req_k], 4'(s)});
          rsp_valid = 1'b1;
          @(posedge clk);
          @(negedge clk);
          rsp_valid = 1'b0;
        end
        req_k++;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(req_k == exp_n, "R2", "request count", 512'(req_k), 512'(exp_n));
    chk(done == 1'b1, "R8", "done timing", 512'(done), 512'(1));
    chk(!req_valid, "R2", "no extra request", 512'(req_valid), 512'(0));
    chk(err == exp_err, "R7", "error flag", 512'(err), 512'(exp_err));
    er = '0;
    for (int i = 0; i < 16; i++)
      if (v[i] && !t_wr) er[i*32 +: 32] = mem_word(t_addr[i][31:2]);
    chk(ret_data == er, "R6", "return data", ret_data, er);
    @(negedge clk);
    chk(!done, "R8", "done pulse", 512'(done), 512'(0));
    chk(msg_ready, "R10", "ready after done", 512'(msg_ready), 512'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; msg_write = 1'b0; msg_en = '0;
    msg_addr = '0; msg_wdata = '0; req_ready = 1'b0; rsp_valid = 1'b0;
    rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msg_ready && !req_valid && !done && ret_data == '0, "R10", "reset state",
        {msg_ready, req_valid, done}, 512'b100);

    // R2: whole message in one line -> one request
    t_wr = 1'b0; t_en = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin t_addr[i] = 32'h0001_0000 + 32'(4*i); t_data[i] = '0; end
    run_msg();
    // R3: every lane in its own line, reversed order
    for (int i = 0; i < 16; i++) t_addr[i] = 32'h0020_0000 + 32'((15 - i) * 64) + 32'(4*i);
    run_msg();
    // R5: all lanes write one slot; highest lane wins
    t_wr = 1'b1;
    for (int i = 0; i < 16; i++) begin t_addr[i] = 32'h0000_4008; t_data[i] = 32'hA000_0000 + 32'(i); end
    run_msg();
    // R6: sparse enables, two lines interleaved
    t_wr = 1'b0; t_en = 16'b0101_1010_0011_1100;
    for (int i = 0; i < 16; i++) t_addr[i] = 32'h0300_0000 + 32'((i % 2) * 64) + 32'(4*(i/2));
    run_msg();
    // R7: misaligned lanes inside the same line and slot as aligned ones
    t_en = 16'hFFFF;
    for (int i = 0; i < 16; i++) t_addr[i] = 32'h0000_8000 + 32'(4*(i/2)) + 32'((i % 4 == 3) ? 1 : 0);
    run_msg();
    // R8: nothing enabled
    t_en = 16'h0000;
    run_msg();
    // R7: everything misaligned
    t_en = 16'hFFFF;
    for (int i = 0; i < 16; i++) t_addr[i] = 32'h0000_9002 + 32'(4*i);
    run_msg();

    // R1: every single lane at every slot
    for (int ln = 0; ln < 16; ln++) begin
      for (int s = 0; s < 16; s++) begin
        t_wr = 1'(s & 1);
        t_en = 16'(1) << ln;
        for (int i = 0; i < 16; i++) begin
          t_addr[i] = 32'h0700_0000 + 32'(ln * 64) + 32'(s * 4);
          t_data[i] = 32'hC000_0000 + 32'(ln * 16 + s);
        end
        run_msg();
      end
    end

    // R2 R3 R4 R5 R6 R7: mixed seeded messages over four lines
    for (int m = 0; m < 300; m++) begin
      logic [31:0] r;
      t_wr = rnd()[7];
      t_en = 16'hFFFF;
      for (int i = 0; i < 16; i++) begin
        r = rnd();
        t_en[i]   = (r[27:25] != 3'd0);
        t_addr[i] = 32'h1000_0000 + 32'(r[9:8]) * 32'd64 + 32'(r[13:10]) * 32'd4
                    + ((r[21:17] == 5'd0) ? 32'(r[1:0] | 2'b01) : 32'd0);
        t_data[i] = rnd();
      end
      run_msg();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule